// File: doc/BRIEF.md
# Interrupt Controller Programming Front End

This block is the register-programming side of one eight-line interrupt controller. Software reaches it through byte writes and reads on two ports: a command port and a data port. Command-port writes either begin a new initialization sequence or issue an operational command. Data-port writes are consumed by the initialization sequence while one is under way, and otherwise load the interrupt mask. The block keeps the resulting configuration (vector base, automatic end-of-interrupt, special fully nested mode, special mask, rotate-on-automatic-EOI, mask) on registered outputs, and it turns end-of-interrupt and priority commands into one-cycle strobes for the priority core next to it.

Reads are answered from the request, in-service and mask bytes the core and this block keep, picked by a read selection that a command sets. A command can also arm a poll: the next read of either port then returns the line the core currently wants to serve (or 7 if none) and sends a one-cycle strobe telling the core to retire that line's request and in-service bits. Arbitration itself lives in the core and is not part of this block; the core supplies its current winner on dedicated inputs.

All state uses a synchronous active-high reset, and every output is a register, so each write or read shows its effect in the cycle after the clock edge that captures it.

Top module: `irqc_prog_front`

## Requirements
- R1: A command-port write with data bit 4 set starts initialization: in the next cycle `init_stb` is high for one cycle, mask, vector base, auto-EOI, nested mode, special mask, rotate-on-auto-EOI, read selection and the armed poll are all zero, and data bit 0 is kept as the "mode word follows" flag.
- R2: The first data-port write after initialization stores data bits [7:3] on `vec_base`.
- R3: The second data-port write after initialization is discarded; it leads to the mode-word step if the kept flag is 1, otherwise back to normal operation, where the next data-port write is a mask write.
- R4: The mode-word data write sets `nest_mode` from data bit 4 and `auto_eoi` from data bit 1, then returns to normal operation.
- R5: A data-port write in normal operation loads `mask_bits` with the written byte.
- R6: A command-port write with bit 4 clear and bit 3 set arms the poll if bit 2 is 1, sets `read_isr` from bit 0 only if bit 1 is 1, and sets `spec_mask` from bit 5 only if bit 6 is 1.
- R7: A command-port write with bits 4 and 3 clear is decoded by bits [7:5]: 1 gives a non-specific EOI strobe, 5 a rotating non-specific EOI, 3 a specific EOI, 7 a rotating specific EOI, 6 a set-priority strobe, and 2 nothing. `eoi_stb` marks any EOI, `eoi_specific` and `eoi_rotate` qualify it; `op_line` carries bits [2:0] for specific EOIs and set-priority, and 0 otherwise.
- R8: Command code 4 in bits [7:5] sets `rot_on_aeoi`, code 0 clears it; neither produces a strobe.
- R9: A read with no poll armed returns, one cycle later on `rd_data`, the mask byte for the data port, or for the command port the in-service byte when `read_isr` is 1 and the request byte when it is 0.
- R10: A read of either port with the poll armed returns the core's winning line number in bits [2:0] and pulses `poll_clr_stb` with `poll_clr_line` set to that line; with no winner it returns 7 and no strobe. The poll is disarmed afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write this cycle |
| wr_port | input | 1 | Write target: 0 command port, 1 data port |
| wr_data | input | 8 | Written byte |
| rd_en | input | 1 | Byte read this cycle |
| rd_port | input | 1 | Read target: 0 command port, 1 data port |
| core_irr | input | 8 | Request byte from the priority core |
| core_isr | input | 8 | In-service byte from the priority core |
| core_win_valid | input | 1 | Core has a line to serve |
| core_win_line | input | 3 | Line the core would serve |
| rd_data | output | 8 | Read result, valid the cycle after the read |
| init_stb | output | 1 | One-cycle initialization strobe to the core |
| vec_base | output | 5 | Vector base, upper five bits of the vector |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| nest_mode | output | 1 | Special fully nested mode |
| mask_bits | output | 8 | Interrupt mask |
| rot_on_aeoi | output | 1 | Rotate priority on automatic EOI |
| spec_mask | output | 1 | Special mask mode |
| read_isr | output | 1 | Command-port reads return in-service byte |
| poll_armed | output | 1 | Next read is a poll |
| eoi_stb | output | 1 | End-of-interrupt strobe |
| eoi_specific | output | 1 | The EOI names a line on op_line |
| eoi_rotate | output | 1 | The EOI also rotates priority |
| prio_stb | output | 1 | Set-lowest-priority strobe for op_line |
| op_line | output | 3 | Line for specific EOI or set-priority |
| poll_clr_stb | output | 1 | Retire request and in-service of poll_clr_line |
| poll_clr_line | output | 3 | Line retired by a poll read |

## Verification
The hardest state to reach from the ports is the second initialization word when no mode word follows: the block must then drop back to normal operation so that the very next data byte lands in the mask, not in the mode flags. The stimulus runs a short sequence without the mode-word flag and writes a byte whose bits 4 and 1 would flip the mode flags if it were wrongly taken as a mode word, then reads the mask and the mode outputs. The poll path is reached by arming a poll with a command and then reading, once with the core presenting a winner and once with none, and by starting initialization while a poll is armed.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  // Steps of the initialization sequence.
  typedef enum logic [1:0] {
    STEP_RUN  = 2'd0,
    STEP_BASE = 2'd1,
    STEP_SKIP = 2'd2,
    STEP_MODE = 2'd3
  } init_step_e;

  // Operation codes held in bits [7:5] of an operation command.
  typedef enum logic [2:0] {
    OP_ROT_OFF = 3'd0,
    OP_EOI     = 3'd1,
    OP_NOP     = 3'd2,
    OP_SEOI    = 3'd3,
    OP_ROT_ON  = 3'd4,
    OP_REOI    = 3'd5,
    OP_SETPRI  = 3'd6,
    OP_RSEOI   = 3'd7
  } op_code_e;

  // Bit positions decoded on the command port.
  localparam int unsigned BIT_INIT    = 4;
  localparam int unsigned BIT_SELCMD  = 3;
  localparam int unsigned BIT_POLL    = 2;
  localparam int unsigned BIT_RSEL_EN = 1;
  localparam int unsigned BIT_RSEL    = 0;
  localparam int unsigned BIT_SMM_EN  = 6;
  localparam int unsigned BIT_SMM     = 5;
  localparam int unsigned BIT_NEED4   = 0;
  // Bit positions in the mode word.
  localparam int unsigned BIT_NEST    = 4;
  localparam int unsigned BIT_AEOI    = 1;
endpackage

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 3,
  localparam int unsigned BW = DW - LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] data,
  output init_step_e    step,
  output logic          init_stb,
  output logic [BW-1:0] vec_base,
  output logic          auto_eoi,
  output logic          nest_mode,
  output logic [DW-1:0] mask_bits
);
  logic need4;

  always_ff @(posedge clk) begin
    if (rst) begin
      step      <= STEP_RUN;
      need4     <= 1'b0;
      init_stb  <= 1'b0;
      vec_base  <= '0;
      auto_eoi  <= 1'b0;
      nest_mode <= 1'b0;
      mask_bits <= '0;
    end else begin
      init_stb <= init_wr;
      if (init_wr) begin
        step      <= STEP_BASE;
        need4     <= data[BIT_NEED4];
        vec_base  <= '0;
        auto_eoi  <= 1'b0;
        nest_mode <= 1'b0;
        mask_bits <= '0;
      end else if (data_wr) begin
        unique case (step)
          STEP_RUN:  mask_bits <= data;
          STEP_BASE: begin
            vec_base <= data[DW-1:LW];
            step     <= STEP_SKIP;
          end
          STEP_SKIP: step <= need4 ? STEP_MODE : STEP_RUN;
          STEP_MODE: begin
            nest_mode <= data[BIT_NEST];
            auto_eoi  <= data[BIT_AEOI];
            step      <= STEP_RUN;
          end
          default:   step <= STEP_RUN;
        endcase
      end
    end
  end

  a_r1_init_clears: assert property (@(posedge clk) disable iff (rst)
    init_wr |=> (init_stb && mask_bits == '0 && vec_base == '0 &&
                 !auto_eoi && !nest_mode && step == STEP_BASE));

  a_r2_base_store: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_BASE && data_wr && !init_wr) |=>
      (vec_base == $past(data[DW-1:LW]) && step == STEP_SKIP));

  a_r3_skip_branch: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_SKIP && data_wr && !init_wr) |=>
      (step == ($past(need4) ? STEP_MODE : STEP_RUN) && $stable(mask_bits)));

  a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
    (step == STEP_RUN && data_wr && !init_wr) |=> (mask_bits == $past(data)));
endmodule

// File: rtl/irqc_op_decode.sv
module irqc_op_decode
  import irqc_pkg::*;
#(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          init_wr,
  input  logic          sel_wr,
  input  logic          op_wr,
  input  logic          poll_take,
  input  logic [DW-1:0] data,
  output logic          rot_on_aeoi,
  output logic          spec_mask,
  output logic          read_isr,
  output logic          poll_armed,
  output logic          eoi_stb,
  output logic          eoi_specific,
  output logic          eoi_rotate,
  output logic          prio_stb,
  output logic [LW-1:0] op_line
);
  op_code_e code;
  logic     is_eoi, is_spec, is_rot, is_pri;

  assign code = op_code_e'(data[DW-1:DW-3]);

  always_comb begin
    is_eoi  = 1'b0;
    is_spec = 1'b0;
    is_rot  = 1'b0;
    is_pri  = 1'b0;
    unique case (code)
      OP_EOI:    is_eoi = 1'b1;
      OP_REOI:   begin is_eoi = 1'b1; is_rot = 1'b1; end
      OP_SEOI:   begin is_eoi = 1'b1; is_spec = 1'b1; end
      OP_RSEOI:  begin is_eoi = 1'b1; is_spec = 1'b1; is_rot = 1'b1; end
      OP_SETPRI: is_pri = 1'b1;
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_on_aeoi  <= 1'b0;
      spec_mask    <= 1'b0;
      read_isr     <= 1'b0;
      poll_armed   <= 1'b0;
      eoi_stb      <= 1'b0;
      eoi_specific <= 1'b0;
      eoi_rotate   <= 1'b0;
      prio_stb     <= 1'b0;
      op_line      <= '0;
    end else begin
      eoi_stb      <= op_wr && is_eoi;
      eoi_specific <= op_wr && is_spec;
      eoi_rotate   <= op_wr && is_rot;
      prio_stb     <= op_wr && is_pri;
      op_line      <= (op_wr && (is_spec || is_pri)) ? data[LW-1:0] : '0;
      if (init_wr) begin
        rot_on_aeoi <= 1'b0;
        spec_mask   <= 1'b0;
        read_isr    <= 1'b0;
        poll_armed  <= 1'b0;
      end else begin
        if (op_wr && code == OP_ROT_ON)  rot_on_aeoi <= 1'b1;
        if (op_wr && code == OP_ROT_OFF) rot_on_aeoi <= 1'b0;
        if (sel_wr && data[BIT_SMM_EN])  spec_mask <= data[BIT_SMM];
        if (sel_wr && data[BIT_RSEL_EN]) read_isr  <= data[BIT_RSEL];
        if (sel_wr && data[BIT_POLL])    poll_armed <= 1'b1;
        else if (poll_take)              poll_armed <= 1'b0;
      end
    end
  end

  a_r7_specific_eoi: assert property (@(posedge clk) disable iff (rst)
    (op_wr && data[DW-1:DW-3] == 3'd3) |=>
      (eoi_stb && eoi_specific && !eoi_rotate && !prio_stb &&
       op_line == $past(data[LW-1:0])));

  a_r7_nop_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_wr && data[DW-1:DW-3] == 3'd2) |=> (!eoi_stb && !prio_stb));

  a_r8_rot_set: assert property (@(posedge clk) disable iff (rst)
    (op_wr && data[DW-1:DW-3] == 3'd4) |=> (rot_on_aeoi && !eoi_stb));

  a_r10_poll_drop: assert property (@(posedge clk) disable iff (rst)
    (poll_take && !(sel_wr && data[BIT_POLL])) |=> !poll_armed);

  a_r1_init_flags: assert property (@(posedge clk) disable iff (rst)
    init_wr |=> (!poll_armed && !read_isr && !spec_mask && !rot_on_aeoi));
endmodule

// File: rtl/irqc_read_mux.sv
module irqc_read_mux #(
  parameter int unsigned DW = 8,
  parameter int unsigned LW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          rd_port,
  input  logic          poll_armed,
  input  logic          read_isr,
  input  logic [DW-1:0] mask_bits,
  input  logic [DW-1:0] core_irr,
  input  logic [DW-1:0] core_isr,
  input  logic          core_win_valid,
  input  logic [LW-1:0] core_win_line,
  output logic [DW-1:0] rd_data,
  output logic          poll_clr_stb,
  output logic [LW-1:0] poll_clr_line
);
  localparam logic [DW-1:0] NONE_CODE = DW'((1 << LW) - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data       <= '0;
      poll_clr_stb  <= 1'b0;
      poll_clr_line <= '0;
    end else begin
      poll_clr_stb <= rd_en && poll_armed && core_win_valid;
      if (rd_en) begin
        if (poll_armed) begin
          rd_data       <= core_win_valid ? DW'(core_win_line) : NONE_CODE;
          poll_clr_line <= core_win_valid ? core_win_line : '0;
        end else if (rd_port) begin
          rd_data <= mask_bits;
        end else begin
          rd_data <= read_isr ? core_isr : core_irr;
        end
      end
    end
  end

  a_r9_mask_read: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !poll_armed && rd_port) |=> (rd_data == $past(mask_bits)));

  a_r10_poll_empty: assert property (@(posedge clk) disable iff (rst)
    (rd_en && poll_armed && !core_win_valid) |=>
      (rd_data == NONE_CODE && !poll_clr_stb));

  a_r10_poll_hit: assert property (@(posedge clk) disable iff (rst)
    (rd_en && poll_armed && core_win_valid) |=>
      (poll_clr_stb && poll_clr_line == $past(core_win_line)));
endmodule

// File: rtl/irqc_prog_front.sv
module irqc_prog_front
  import irqc_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned LINES = 8,
  localparam int unsigned LW   = $clog2(LINES),
  localparam int unsigned BW   = DW - LW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_port,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          rd_port,
  input  logic [DW-1:0] core_irr,
  input  logic [DW-1:0] core_isr,
  input  logic          core_win_valid,
  input  logic [LW-1:0] core_win_line,
  output logic [DW-1:0] rd_data,
  output logic          init_stb,
  output logic [BW-1:0] vec_base,
  output logic          auto_eoi,
  output logic          nest_mode,
  output logic [DW-1:0] mask_bits,
  output logic          rot_on_aeoi,
  output logic          spec_mask,
  output logic          read_isr,
  output logic          poll_armed,
  output logic          eoi_stb,
  output logic          eoi_specific,
  output logic          eoi_rotate,
  output logic          prio_stb,
  output logic [LW-1:0] op_line,
  output logic          poll_clr_stb,
  output logic [LW-1:0] poll_clr_line
);
  logic       cmd_wr, init_wr, sel_wr, op_wr, data_wr, poll_take;
  init_step_e step;

  assign cmd_wr    = wr_en && !wr_port;
  assign data_wr   = wr_en && wr_port;
  assign init_wr   = cmd_wr && wr_data[BIT_INIT];
  assign sel_wr    = cmd_wr && !wr_data[BIT_INIT] && wr_data[BIT_SELCMD];
  assign op_wr     = cmd_wr && !wr_data[BIT_INIT] && !wr_data[BIT_SELCMD];
  assign poll_take = rd_en && poll_armed;

  irqc_init_seq #(.DW(DW), .LW(LW)) u_init (
    .clk(clk), .rst(rst), .init_wr(init_wr), .data_wr(data_wr),
    .data(wr_data), .step(step), .init_stb(init_stb), .vec_base(vec_base),
    .auto_eoi(auto_eoi), .nest_mode(nest_mode), .mask_bits(mask_bits)
  );

  irqc_op_decode #(.DW(DW), .LW(LW)) u_ops (
    .clk(clk), .rst(rst), .init_wr(init_wr), .sel_wr(sel_wr), .op_wr(op_wr),
    .poll_take(poll_take), .data(wr_data), .rot_on_aeoi(rot_on_aeoi),
    .spec_mask(spec_mask), .read_isr(read_isr), .poll_armed(poll_armed),
    .eoi_stb(eoi_stb), .eoi_specific(eoi_specific), .eoi_rotate(eoi_rotate),
    .prio_stb(prio_stb), .op_line(op_line)
  );

  irqc_read_mux #(.DW(DW), .LW(LW)) u_read (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_port(rd_port),
    .poll_armed(poll_armed), .read_isr(read_isr), .mask_bits(mask_bits),
    .core_irr(core_irr), .core_isr(core_isr), .core_win_valid(core_win_valid),
    .core_win_line(core_win_line), .rd_data(rd_data),
    .poll_clr_stb(poll_clr_stb), .poll_clr_line(poll_clr_line)
  );

  a_r6_step_legal: assert property (@(posedge clk) disable iff (rst)
    sel_wr |=> $stable(mask_bits));
endmodule

// File: tb/irqc_prog_front_tb.sv
module irqc_prog_front_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, wr_port = 1'b0, rd_en = 1'b0, rd_port = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] core_irr = 8'h5A, core_isr = 8'hA5;
  logic       core_win_valid = 1'b0;
  logic [2:0] core_win_line = 3'd0;
  logic [7:0] rd_data, mask_bits;
  logic [4:0] vec_base;
  logic [2:0] op_line, poll_clr_line;
  logic init_stb, auto_eoi, nest_mode, rot_on_aeoi, spec_mask, read_isr;
  logic poll_armed, eoi_stb, eoi_specific, eoi_rotate, prio_stb, poll_clr_stb;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  irqc_prog_front u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .rd_en(rd_en), .rd_port(rd_port), .core_irr(core_irr), .core_isr(core_isr),
    .core_win_valid(core_win_valid), .core_win_line(core_win_line),
    .rd_data(rd_data), .init_stb(init_stb), .vec_base(vec_base),
    .auto_eoi(auto_eoi), .nest_mode(nest_mode), .mask_bits(mask_bits),
    .rot_on_aeoi(rot_on_aeoi), .spec_mask(spec_mask), .read_isr(read_isr),
    .poll_armed(poll_armed), .eoi_stb(eoi_stb), .eoi_specific(eoi_specific),
    .eoi_rotate(eoi_rotate), .prio_stb(prio_stb), .op_line(op_line),
    .poll_clr_stb(poll_clr_stb), .poll_clr_line(poll_clr_line)
  );

  // Entry: {req[3:0], read, port, data[7:0], expected[7:0]}.
  // Writes compare the strobe byte {init_stb, eoi_stb, eoi_specific,
  // eoi_rotate, prio_stb, op_line}; reads compare rd_data.
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {4'd1,  1'b0, 1'b0, 8'h11, 8'h80},  // R1 init, mode word follows
    {4'd2,  1'b0, 1'b1, 8'h48, 8'h00},  // R2 base = 9
    {4'd3,  1'b0, 1'b1, 8'h00, 8'h00},  // R3 discarded word
    {4'd4,  1'b0, 1'b1, 8'h12, 8'h00},  // R4 nested + auto EOI
    {4'd5,  1'b0, 1'b1, 8'hF0, 8'h00},  // R5 mask
    {4'd9,  1'b1, 1'b1, 8'h00, 8'hF0},  // R9 mask read
    {4'd7,  1'b0, 1'b0, 8'h20, 8'h40},  // R7 non-specific EOI
    {4'd7,  1'b0, 1'b0, 8'h63, 8'h63},  // R7 specific EOI line 3
    {4'd7,  1'b0, 1'b0, 8'hA0, 8'h50},  // R7 rotating non-specific
    {4'd7,  1'b0, 1'b0, 8'hE5, 8'h75},  // R7 rotating specific line 5
    {4'd7,  1'b0, 1'b0, 8'hC6, 8'h0E},  // R7 set priority line 6
    {4'd7,  1'b0, 1'b0, 8'h47, 8'h00},  // R7 code 2 does nothing
    {4'd6,  1'b0, 1'b0, 8'h0A, 8'h00},  // R6 select request byte
    {4'd9,  1'b1, 1'b0, 8'h00, 8'h5A},  // R9 request read
    {4'd6,  1'b0, 1'b0, 8'h0B, 8'h00},  // R6 select in-service byte
    {4'd9,  1'b1, 1'b0, 8'h00, 8'hA5},  // R9 in-service read
    {4'd5,  1'b0, 1'b1, 8'h3C, 8'h00},  // R5 mask in normal operation
    {4'd9,  1'b1, 1'b1, 8'h00, 8'h3C}   // R9 mask read
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  function automatic logic [7:0] stb_byte();
    return {init_stb, eoi_stb, eoi_specific, eoi_rotate, prio_stb, op_line};
  endfunction

  task automatic do_wr(input logic port, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_port = port; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic port);
    @(negedge clk);
    rd_en = 1'b1; rd_port = port;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Reset state (R1 values held at reset, R9 default selection).
    chk("R1", "reset mask", mask_bits, 8'h00);
    chk("R1", "reset flags",
        {vec_base, auto_eoi, nest_mode, poll_armed}, 8'h00);
    do_rd(1'b0);
    chk("R9", "reset command read is request byte", rd_data, 8'h5A);

    for (int i = 0; i < NV; i++) begin
      logic [21:0] v;
      v = VEC[i];
      if (v[17]) begin
        do_rd(v[16]);
        chk($sformatf("R%0d", v[21:18]), $sformatf("vector %0d read", i),
            rd_data, v[7:0]);
      end else begin
        do_wr(v[16], v[15:8]);
        chk($sformatf("R%0d", v[21:18]), $sformatf("vector %0d strobes", i),
            stb_byte(), v[7:0]);
      end
    end
    chk("R2", "vector base", {3'b0, vec_base}, 8'h09);
    chk("R4", "mode flags", {6'b0, nest_mode, auto_eoi}, 8'h03);

    // R8: rotate-on-auto-EOI set and clear.
    do_wr(1'b0, 8'h80);
    chk("R8", "rotate set", {rot_on_aeoi, stb_byte()[6:0]}, 8'h80);
    do_wr(1'b0, 8'h00);
    chk("R8", "rotate clear", {7'b0, rot_on_aeoi}, 8'h00);

    // R6: special mask only changes when bit 6 is set.
    do_wr(1'b0, 8'h68);
    chk("R6", "special mask set", {7'b0, spec_mask}, 8'h01);
    do_wr(1'b0, 8'h08);
    chk("R6", "special mask held, read select held",
        {6'b0, spec_mask, read_isr}, 8'h03);
    do_wr(1'b0, 8'h48);
    chk("R6", "special mask cleared", {7'b0, spec_mask}, 8'h00);

    // R10: poll with a winner on line 4.
    core_win_valid = 1'b1; core_win_line = 3'd4;
    do_wr(1'b0, 8'h0C);
    chk("R6", "poll armed", {7'b0, poll_armed}, 8'h01);
    do_rd(1'b0);
    chk("R10", "poll read value", rd_data, 8'h04);
    chk("R10", "poll clear strobe", {4'b0, poll_clr_stb, poll_clr_line}, 8'h0C);
    chk("R10", "poll disarmed", {7'b0, poll_armed}, 8'h00);
    do_rd(1'b0);
    chk("R10", "read after poll is in-service byte", rd_data, 8'hA5);
    chk("R10", "no strobe after poll", {7'b0, poll_clr_stb}, 8'h00);

    // R10: poll with no winner, through the data port.
    core_win_valid = 1'b0;
    do_wr(1'b0, 8'h0C);
    do_rd(1'b1);
    chk("R10", "empty poll value", rd_data, 8'h07);
    chk("R10", "empty poll strobe", {7'b0, poll_clr_stb}, 8'h00);

    // R1: initialization while poll armed, no mode word.
    do_wr(1'b0, 8'h0C);
    do_wr(1'b0, 8'h10);
    chk("R1", "init strobe", stb_byte(), 8'h80);
    chk("R1", "init clears state",
        {mask_bits[3:0], auto_eoi, nest_mode, poll_armed, read_isr}, 8'h00);
    chk("R1", "init clears special/rotate",
        {6'b0, spec_mask, rot_on_aeoi}, 8'h00);
    chk("R1", "init clears base", {3'b0, vec_base}, 8'h00);
    @(negedge clk);
    chk("R1", "init strobe is one cycle", {7'b0, init_stb}, 8'h00);
    do_wr(1'b1, 8'h80);
    chk("R2", "second base", {3'b0, vec_base}, 8'h10);
    do_wr(1'b1, 8'hFF);
    chk("R3", "discarded word leaves mask", mask_bits, 8'h00);
    // R3: no mode word expected, so this byte is a mask, not mode flags.
    do_wr(1'b1, 8'h12);
    chk("R3", "byte after short init goes to mask", mask_bits, 8'h12);
    chk("R3", "mode flags untouched", {6'b0, nest_mode, auto_eoi}, 8'h00);
    do_rd(1'b0);
    chk("R9", "init restored request selection", rd_data, 8'h5A);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule